// File: doc/BRIEF.md
# Prefixed instruction fetch combiner

This block sits between a word-addressed instruction memory and an instruction decoder. It reads one 32-bit word at a time through a single-outstanding request/response port and checks each word for a vector prefix signature. A plain word goes to the decoder unchanged, with a zero remap field. A prefix word starts a second read at the following word. That suffix word is then presented as the instruction, together with the 24-bit remap field gathered from the prefix.

The decoder sees one registered record per instruction: the instruction word, the remap field and its split-out subfields, a prefixed flag and the byte PC of the instruction. The record is held until the decoder takes it with valid/ready. Fetching runs while `run` is high. A response flagged as missing raises a one-cycle error pulse and parks the block in idle, with the PC left on the instruction that failed.

Top module: `vpfx_fetch`

## Requirements
- R1: After synchronous reset the outputs are `out_valid`=0, `mem_req`=0, `err`=0 and `out_pc`=0 (the reset PC).
- R2: In idle with `run` low, no memory request is issued and no instruction is presented.
- R3: Bits are numbered MSB-first, so bit k is `word[31-k]`. A word is a prefix only when bits 0-5 (`word[31:26]`) equal 1, bit 7 (`word[24]`) is 1 and bit 9 (`word[22]`) is 1. Any other word is plain, including a word with major opcode 1 and only one of the two marker bits set, and a word with both marker bits set under another major opcode.
- R4: A plain word is presented with `out_insn` equal to the word, `out_remap`=0, `out_pfx`=0 and `out_pc` equal to its byte address.
- R5: For a prefix at byte PC p, the block requests word address p/4+1. It then presents `out_insn` equal to that suffix word, `out_remap` = {`word[25]`, `word[23]`, `word[21:0]`} of the prefix (MSB-first bits 6, 8, then 10 through 31), `out_pfx`=1 and `out_pc`=p.
- R6: The remap subfields are driven from `out_remap`: `rm_mmode`=[23], `rm_mask`=[22:20], `rm_elw`=[19:18], `rm_srcelw`=[17:16], `rm_subvl`=[15:14], `rm_extra`=[13:5], `rm_mode`=[4:0].
- R7: Instructions are presented in program order. The next instruction's PC is the current PC plus 8 after a prefixed instruction and plus 4 otherwise.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all presented values hold.
- R9: `mem_req` is high for single cycles only, and no further request is issued until the response to the previous one has arrived.
- R10: A response with `mem_rmiss` high, for either the first word or the suffix, pulses `err` for one cycle with `out_valid` low. It sets `out_pc` to the PC of the instruction being fetched and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Fetch enable; idle holds while low |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_rvalid | input | 1 | Response strobe |
| mem_rmiss | input | 1 | With `mem_rvalid`: no instruction at that address |
| mem_rdata | input | 32 | Response word |
| out_valid | output | 1 | Instruction record is valid |
| out_ready | input | 1 | Decoder accepts the record |
| out_insn | output | 32 | Plain word or suffix word |
| out_remap | output | 24 | Gathered remap field, zero for plain words |
| out_pfx | output | 1 | Record came from a prefixed pair |
| out_pc | output | ADDR_W+2 | Byte PC of the instruction (failing PC after an error) |
| err | output | 1 | One-cycle missing-instruction pulse |
| rm_mmode | output | 1 | Remap mask-mode bit |
| rm_mask | output | 3 | Remap mask selector |
| rm_elw | output | 2 | Remap element width |
| rm_srcelw | output | 2 | Remap source element width |
| rm_subvl | output | 2 | Remap sub-vector length |
| rm_extra | output | 9 | Remap extra field |
| rm_mode | output | 5 | Remap mode field |

## Verification
A plain word's record turns valid on the first edge after its response. A prefix issues the suffix request on the first edge after the prefix response, and its record turns valid one edge after the suffix response. The next request leaves on the same edge that accepts a record, and `err` rises one edge after a missing response. Memory latency is randomised, so the bench does not count cycles. It samples on falling edges, takes each record at the moment a handshake is due, compares it in order against a list built from the memory image, and checks held values across consecutive falling edges whenever the decoder stalls.

// File: rtl/vpfx_pkg.sv
package vpfx_pkg;
  localparam int WORD_W  = 32;
  localparam int REMAP_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH_WORD,
    ST_FETCH_SUFFIX,
    ST_PRESENT
  } fetch_st_e;

  // Remap field, MSB-first subfield order
  typedef struct packed {
    logic       mmode;
    logic [2:0] mask;
    logic [1:0] elw;
    logic [1:0] srcelw;
    logic [1:0] subvl;
    logic [8:0] extra;
    logic [4:0] mode;
  } remap_t;

  // MSB-first source bit in the prefix word for MSB-first remap bit i
  function automatic int gather_src(input int i);
    if (i == 0)      return 6;
    else if (i == 1) return 8;
    else             return i + 8;
  endfunction
endpackage

// File: rtl/vpfx_sig_decode.sv
module vpfx_sig_decode
  import vpfx_pkg::*;
#(
  parameter int          W      = WORD_W,
  parameter int          RW     = REMAP_W,
  parameter logic [5:0]  MAJOR  = 6'd1
) (
  input  logic [W-1:0]  word,
  output logic          is_pfx,
  output logic [RW-1:0] remap
);
  localparam int MAJ_W = 6;
  localparam int MARK_A = 7;
  localparam int MARK_B = 9;

  // scattered field gather: pure wiring
  for (genvar i = 0; i < RW; i++) begin : g_gather
    assign remap[RW-1-i] = word[W-1-gather_src(i)];
  end

  assign is_pfx = (word[W-1 -: MAJ_W] == MAJOR) &&
                  word[W-1-MARK_A] && word[W-1-MARK_B];
endmodule

// File: rtl/vpfx_remap_split.sv
module vpfx_remap_split
  import vpfx_pkg::*;
(
  input  logic [REMAP_W-1:0] remap,
  output logic               mmode,
  output logic [2:0]         mask,
  output logic [1:0]         elw,
  output logic [1:0]         srcelw,
  output logic [1:0]         subvl,
  output logic [8:0]         extra,
  output logic [4:0]         mode
);
  remap_t f;
  assign f      = remap_t'(remap);
  assign mmode  = f.mmode;
  assign mask   = f.mask;
  assign elw    = f.elw;
  assign srcelw = f.srcelw;
  assign subvl  = f.subvl;
  assign extra  = f.extra;
  assign mode   = f.mode;
endmodule

// File: rtl/vpfx_fetch_fsm.sv
module vpfx_fetch_fsm
  import vpfx_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned RESET_WORD = 0,
  localparam int         PC_W       = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic               mem_rmiss,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               is_pfx,
  input  logic [REMAP_W-1:0] remap,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_insn,
  output logic [REMAP_W-1:0] out_remap,
  output logic               out_pfx,
  output logic [PC_W-1:0]    out_pc,
  output logic               err
);
  localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_WORD) << 2;

  fetch_st_e          st;
  logic [PC_W-1:0]    pc;
  logic [REMAP_W-1:0] remap_q;
  logic [PC_W-1:0]    next_pc;

  assign next_pc = pc + (out_pfx ? PC_W'(8) : PC_W'(4));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pc        <= PC_RST;
      remap_q   <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      out_valid <= 1'b0;
      out_insn  <= '0;
      out_remap <= '0;
      out_pfx   <= 1'b0;
      out_pc    <= PC_RST;
      err       <= 1'b0;
    end else begin
      mem_req <= 1'b0;
      err     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (run) begin
            mem_req  <= 1'b1;
            mem_addr <= pc[PC_W-1:2];
            st       <= ST_FETCH_WORD;
          end
        end
        ST_FETCH_WORD: begin
          if (mem_rvalid) begin
            if (mem_rmiss) begin
              err    <= 1'b1;
              out_pc <= pc;
              st     <= ST_IDLE;
            end else if (is_pfx) begin
              remap_q  <= remap;
              mem_req  <= 1'b1;
              mem_addr <= pc[PC_W-1:2] + ADDR_W'(1);
              st       <= ST_FETCH_SUFFIX;
            end else begin
              out_insn  <= mem_rdata;
              out_remap <= '0;
              out_pfx   <= 1'b0;
              out_pc    <= pc;
              out_valid <= 1'b1;
              st        <= ST_PRESENT;
            end
          end
        end
        ST_FETCH_SUFFIX: begin
          if (mem_rvalid) begin
            if (mem_rmiss) begin
              err    <= 1'b1;
              out_pc <= pc;
              st     <= ST_IDLE;
            end else begin
              out_insn  <= mem_rdata;
              out_remap <= remap_q;
              out_pfx   <= 1'b1;
              out_pc    <= pc;
              out_valid <= 1'b1;
              st        <= ST_PRESENT;
            end
          end
        end
        ST_PRESENT: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            pc        <= next_pc;
            if (run) begin
              mem_req  <= 1'b1;
              mem_addr <= next_pc[PC_W-1:2];
              st       <= ST_FETCH_WORD;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: requests are single-cycle pulses
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R9: nothing new while a response is awaited
  assert_req_wait_R9: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_FETCH_WORD || st == ST_FETCH_SUFFIX) && !mem_rvalid) |=> !mem_req);

  // R2: idle with run low stays quiet
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !run) |=> !mem_req && !out_valid);

  // R8: presented record holds while stalled
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_insn) &&
      $stable(out_remap) && $stable(out_pfx) && $stable(out_pc));

  // R10: error never coincides with a valid record
  assert_err_novalid_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> !out_valid);
endmodule

// File: rtl/vpfx_fetch.sv
module vpfx_fetch
  import vpfx_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int unsigned RESET_WORD = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic               mem_rmiss,
  input  logic [31:0]        mem_rdata,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_insn,
  output logic [23:0]        out_remap,
  output logic               out_pfx,
  output logic [ADDR_W+1:0]  out_pc,
  output logic               err,
  output logic               rm_mmode,
  output logic [2:0]         rm_mask,
  output logic [1:0]         rm_elw,
  output logic [1:0]         rm_srcelw,
  output logic [1:0]         rm_subvl,
  output logic [8:0]         rm_extra,
  output logic [4:0]         rm_mode
);
  localparam int PC_W = ADDR_W + 2;

  logic               dec_pfx;
  logic [REMAP_W-1:0] dec_remap;

  vpfx_sig_decode #(.W(WORD_W), .RW(REMAP_W), .MAJOR(6'd1)) u_dec (
    .word   (mem_rdata),
    .is_pfx (dec_pfx),
    .remap  (dec_remap)
  );

  vpfx_fetch_fsm #(.ADDR_W(ADDR_W), .RESET_WORD(RESET_WORD)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rmiss  (mem_rmiss),
    .mem_rdata  (mem_rdata),
    .is_pfx     (dec_pfx),
    .remap      (dec_remap),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_insn   (out_insn),
    .out_remap  (out_remap),
    .out_pfx    (out_pfx),
    .out_pc     (out_pc),
    .err        (err)
  );

  vpfx_remap_split u_split (
    .remap  (out_remap),
    .mmode  (rm_mmode),
    .mask   (rm_mask),
    .elw    (rm_elw),
    .srcelw (rm_srcelw),
    .subvl  (rm_subvl),
    .extra  (rm_extra),
    .mode   (rm_mode)
  );

  // R4: plain records carry no remap bits
  assert_plain_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_pfx) |-> (out_remap == '0));

  // R7: the request after an accepted record targets the next instruction
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && run) |=> mem_req &&
      (mem_addr == $past(out_pc[PC_W-1:2]) + ($past(out_pfx) ? ADDR_W'(2) : ADDR_W'(1))));
endmodule

// File: tb/tb_vpfx_fetch.sv
`timescale 1ns/1ps
module tb_vpfx_fetch;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic mem_rmiss = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_insn;
  logic [23:0] out_remap;
  logic out_pfx;
  logic [AW+1:0] out_pc;
  logic err;
  logic rm_mmode;
  logic [2:0] rm_mask;
  logic [1:0] rm_elw, rm_srcelw, rm_subvl;
  logic [8:0] rm_extra;
  logic [4:0] rm_mode;

  always #4 clk = ~clk;

  vpfx_fetch #(.ADDR_W(AW), .RESET_WORD(0)) dut (
    .clk(clk), .rst(rst), .run(run),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rmiss(mem_rmiss), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_remap(out_remap), .out_pfx(out_pfx),
    .out_pc(out_pc), .err(err),
    .rm_mmode(rm_mmode), .rm_mask(rm_mask), .rm_elw(rm_elw),
    .rm_srcelw(rm_srcelw), .rm_subvl(rm_subvl), .rm_extra(rm_extra),
    .rm_mode(rm_mode)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_pfx(input logic [31:0] w);
    return (w[31:26] == 6'd1) && w[24] && w[22];
  endfunction

  function automatic logic [23:0] remap_of(input logic [31:0] w);
    return {w[25], w[23], w[21:0]};
  endfunction

  // memory model
  logic [31:0] mem [0:63];
  int mem_limit = 40;
  int req_count = 0;
  bit pend = 0;
  logic [AW-1:0] paddr = '0;
  int wait_c = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_rmiss  <= 1'b0;
    if (rst) begin
      pend <= 0;
    end else if (mem_req) begin
      pend      <= 1;
      paddr     <= mem_addr;
      wait_c    <= int'($urandom % 3);
      req_count <= req_count + 1;
    end else if (pend) begin
      if (wait_c == 0) begin
        pend       <= 0;
        mem_rvalid <= 1'b1;
        if (int'(paddr) >= mem_limit) mem_rmiss <= 1'b1;
        else mem_rdata <= mem[paddr[5:0]];
      end else begin
        wait_c <= wait_c - 1;
      end
    end
  end

  // expected stream
  logic [31:0] exp_insn  [0:63];
  logic [23:0] exp_remap [0:63];
  bit          exp_pfx   [0:63];
  int          exp_pc    [0:63];
  int n_exp = 0;
  int exp_err_pc = 0;

  task automatic build_expect();
    int pc;
    int wi;
    pc = 0;
    n_exp = 0;
    while (1) begin
      wi = pc / 4;
      if (wi >= mem_limit) begin exp_err_pc = pc; break; end
      if (is_pfx(mem[wi])) begin
        if (wi + 1 >= mem_limit) begin exp_err_pc = pc; break; end
        exp_insn[n_exp] = mem[wi+1]; exp_remap[n_exp] = remap_of(mem[wi]);
        exp_pfx[n_exp] = 1; exp_pc[n_exp] = pc; n_exp++;
        pc += 8;
      end else begin
        exp_insn[n_exp] = mem[wi]; exp_remap[n_exp] = '0;
        exp_pfx[n_exp] = 0; exp_pc[n_exp] = pc; n_exp++;
        pc += 4;
      end
    end
  endtask

  // monitor and ready driver
  int idx = 0;
  bit prev_stall = 0;
  bit rand_ready = 0;
  logic [31:0] h_insn;
  logic [23:0] h_remap;
  bit h_pfx;
  logic [AW+1:0] h_pc;

  always @(negedge clk) begin
    if (rst) begin
      idx = 0;
      prev_stall = 0;
      out_ready = 1'b1;
    end else begin
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R8", "valid held", 64'(out_valid), 64'd1);
        chk(out_insn == h_insn && out_remap == h_remap && out_pfx == h_pfx && out_pc == h_pc,
            "R8", "record held", {out_insn, out_remap, 8'(out_pc)}, {h_insn, h_remap, 8'(h_pc)});
      end
      out_ready = rand_ready ? (($urandom % 10) < 6) : 1'b1;
      if (out_valid && out_ready) begin
        if (idx >= n_exp) begin
          chk(0, "R7", "extra record", 64'(out_pc), 64'(exp_err_pc));
        end else begin
          chk(out_pc == (AW+2)'(exp_pc[idx]), "R7", "pc order", 64'(out_pc), 64'(exp_pc[idx]));
          chk(out_pfx == exp_pfx[idx], exp_pfx[idx] ? "R3" : "R3", "prefix flag",
              64'(out_pfx), 64'(exp_pfx[idx]));
          chk(out_insn == exp_insn[idx], exp_pfx[idx] ? "R5" : "R4", "insn",
              64'(out_insn), 64'(exp_insn[idx]));
          chk(out_remap == exp_remap[idx], exp_pfx[idx] ? "R5" : "R4", "remap",
              64'(out_remap), 64'(exp_remap[idx]));
          chk({rm_mmode, rm_mask, rm_elw, rm_srcelw, rm_subvl, rm_extra, rm_mode} == exp_remap[idx],
              "R6", "subfields", 64'({rm_mmode, rm_mask, rm_elw, rm_srcelw, rm_subvl, rm_extra, rm_mode}),
              64'(exp_remap[idx]));
          idx++;
        end
      end
      if (err) begin
        chk(idx == n_exp, "R10", "error after all records", 64'(idx), 64'(n_exp));
        chk(out_pc == (AW+2)'(exp_err_pc), "R10", "error pc", 64'(out_pc), 64'(exp_err_pc));
        chk(!out_valid, "R10", "no valid with error", 64'(out_valid), 64'd0);
      end
      prev_stall = out_valid && !out_ready;
      h_insn = out_insn; h_remap = out_remap; h_pfx = out_pfx; h_pc = out_pc;
    end
  end

  task automatic fill_phase1();
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    mem[0] = 32'h07FF_FFFF;   // prefix, all remap bits set
    mem[1] = 32'hDEAD_BEEF;
    mem[2] = 32'h0540_0000;   // prefix, remap zero
    mem[3] = 32'h1234_5678;
    mem[4] = 32'h0500_0000;   // major 1, only bit 7 set: plain
    mem[5] = 32'h0940_0000;   // major 2, both markers: plain
    for (int i = 6; i < 38; i++) begin
      if (($urandom % 10) < 4) mem[i] = {6'd1, 1'($urandom), 1'b1, 1'($urandom), 1'b1, 22'($urandom)};
    end
    mem[38] = 32'h6000_0000;
    mem[39] = {6'd1, 1'b0, 1'b1, 1'b1, 1'b1, 22'h2A_5A5A}; // prefix, suffix missing
  endtask

  task automatic wait_err_and_park(input string req);
    int snap;
    while (!err) @(negedge clk);
    run = 0;
    snap = req_count;
    repeat (10) @(negedge clk);
    chk(req_count == snap, req, "idle after error", 64'(req_count), 64'(snap));
    chk(!out_valid && !mem_req, req, "quiet after error", {62'd0, out_valid, mem_req}, 64'd0);
    chk(idx == n_exp, "R7", "record count", 64'(idx), 64'(n_exp));
  endtask

  initial begin
    int snap;
    void'($urandom(32'd20240611));
    fill_phase1();
    mem_limit = 40;
    build_expect();
    rst = 1; run = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !mem_req && !err, "R1", "reset outputs",
        {61'd0, out_valid, mem_req, err}, 64'd0);
    chk(out_pc == '0, "R1", "reset pc", 64'(out_pc), 64'd0);
    snap = req_count;
    repeat (6) @(negedge clk);
    chk(req_count == snap && !out_valid, "R2", "no fetch while run low",
        64'(req_count), 64'(snap));

    // phase 1: mixed stream, stalls, suffix missing at end
    rand_ready = 1;
    run = 1;
    wait_err_and_park("R10");

    // phase 2: plain near-miss words, first-word miss
    rst = 1;
    mem[0] = 32'h0500_0000;
    mem[1] = 32'h0940_0000;
    mem[2] = 32'h0440_0000;
    mem_limit = 3;
    build_expect();
    repeat (2) @(negedge clk);
    rst = 0;
    rand_ready = 0;
    @(negedge clk);
    run = 1;
    wait_err_and_park("R10");
    chk(exp_err_pc == 12, "R3", "near-miss words stayed plain", 64'(exp_err_pc), 64'd12);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule